// File: doc/BRIEF.md
# Split TLB Translation and Permission Checker

This block translates a virtual address into a physical address for a paged memory management unit that keeps two direct-mapped translation buffers: one for instruction fetches and one for data accesses. Each entry holds a match word (virtual page and valid bit) and a translate word (physical page and permission bits). A lookup reads the instruction and data entries at the same index together. It merges them into one permission vector and then decides whether the access succeeds, hits a page fault or misses the buffer.

If the two entries at an index point to different physical pages, the entry that the current access does not need is discarded before any check is made. A fetch keeps the instruction entry and any other access keeps the data entry. With translation turned off, the address passes through unchanged with full rights. Entries are loaded through a one-entry-per-cycle write port. The result is registered and appears one cycle after the request.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_paddr, rsp_perm and rsp_fault are 0, and every entry of both buffers is invalid, so a translated lookup misses.
- R2: A request with req_valid high produces rsp_valid high exactly one cycle later, carrying that request's result. rsp_valid is low in every cycle that follows a cycle without a request.
- R3: With req_mmu_en low, rsp_paddr equals req_vaddr, rsp_perm is 3'b111 and rsp_fault is 0, whatever the buffers hold.
- R4: Both buffers are indexed by virtual address bits [18:13]. An entry matches when match-word bits [31:13] equal virtual address bits [31:13]. Match-word bit 0 is the valid bit. The permission vector is bit 0 read, bit 1 write, bit 2 execute.
- R5: When translate-word bits [31:13] of the two entries at the index differ, a fetch ignores the data entry and a load or store ignores the instruction entry.
- R6: Execute is granted by instruction translate-word bit 7 in supervisor mode and bit 6 in user mode. Read is granted by data translate-word bit 8 in supervisor mode and bit 6 in user mode. Write is granted by data bit 9 in supervisor mode and bit 7 in user mode. A right is only granted through a valid, matching entry.
- R7: rsp_paddr bits [31:13] are the OR of the kept translate words' bits [31:13], and bits [12:0] are the virtual offset.
- R8: The access encoding is fetch=0, load=1, store=2, and 3 is treated as a load. A fetch needs execute, a load needs read and a store needs write.
- R9: The fault codes are 0 none, 1 instruction page fault, 2 data page fault, 3 instruction buffer miss and 4 data buffer miss. If the needed right is missing, the fault is a page fault when the entry that grants it is valid and matching, and a miss otherwise.
- R10: A buffer write in the same cycle as a lookup to the same index is not seen by that lookup, but is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_super | input | 1 | Supervisor privilege |
| req_mmu_en | input | 1 | Translation enabled |
| wr_en | input | 1 | Buffer entry write |
| wr_sel_data | input | 1 | 0 selects the instruction buffer, 1 selects the data buffer |
| wr_idx | input | 6 | Entry index to write |
| wr_match | input | 32 | Match word to store |
| wr_xlate | input | 32 | Translate word to store |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_fault | output | 3 | Fault code |

## Verification
The hardest case to reach is the page conflict. The instruction and data entries at one index must both be present and valid, yet point to different physical pages, so that the outcome depends only on which entry the access type keeps. The stimulus writes such a pair at one index and fetches, then loads the same address, expecting rights and addresses from different entries. A second hard case is a lookup and a write to the same index in the same cycle. It is driven by holding both ports in one clock and checking that the result first shows a miss and then a hit.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam int BIT_UX = 6;
  localparam int BIT_SX = 7;
  localparam int BIT_UR = 6;
  localparam int BIT_UW = 7;
  localparam int BIT_SR = 8;
  localparam int BIT_SW = 9;

  localparam logic [2:0] FLT_NONE  = 3'd0;
  localparam logic [2:0] FLT_IPAGE = 3'd1;
  localparam logic [2:0] FLT_DPAGE = 3'd2;
  localparam logic [2:0] FLT_IMISS = 3'd3;
  localparam logic [2:0] FLT_DMISS = 3'd4;

  function automatic logic [2:0] need_of(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: need_of = 3'b100;
      ACC_STORE: need_of = 3'b010;
      default:   need_of = 3'b001;
    endcase
  endfunction

  function automatic logic [2:0] classify(input logic [2:0] need, input logic [2:0] rights,
                                          input logic [2:0] valid, input logic fetch);
    if ((need & rights) != 3'b000)     classify = FLT_NONE;
    else if ((need & valid) != 3'b000) classify = fetch ? FLT_IPAGE : FLT_DPAGE;
    else                               classify = fetch ? FLT_IMISS : FLT_DMISS;
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_match,
  input  logic [ADDR_W-1:0] wr_xlate,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_match,
  output logic [ADDR_W-1:0] rd_xlate
);
  logic [ADDR_W-1:0] match_q [DEPTH];
  logic [ADDR_W-1:0] xlate_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        match_q[i] <= '0;
        xlate_q[i] <= '0;
      end
    end else if (wr_en) begin
      match_q[wr_idx] <= wr_match;
      xlate_q[wr_idx] <= wr_xlate;
    end
  end

  assign rd_match = match_q[rd_idx];
  assign rd_xlate = xlate_q[rd_idx];
endmodule

// File: rtl/tlb_merge_check.sv
module tlb_merge_check
  import tlb_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        acc,
  input  logic              super_mode,
  input  logic [ADDR_W-1:0] imr,
  input  logic [ADDR_W-1:0] itr,
  input  logic [ADDR_W-1:0] dmr,
  input  logic [ADDR_W-1:0] dtr,
  output logic              pages_differ,
  output logic [2:0]        match_v,
  output logic [2:0]        valid_v,
  output logic [2:0]        rights_v,
  output logic [ADDR_W-1:0] paddr,
  output logic [2:0]        fault
);
  localparam int VPN_W = ADDR_W - PAGE_BITS;

  logic              is_fetch;
  logic [ADDR_W-1:0] imr_k, itr_k, dmr_k, dtr_k;
  logic [VPN_W-1:0]  vpn;
  logic              i_hit, d_hit;

  assign vpn          = vaddr[ADDR_W-1:PAGE_BITS];
  assign is_fetch     = (acc == ACC_FETCH);
  assign pages_differ = itr[ADDR_W-1:PAGE_BITS] != dtr[ADDR_W-1:PAGE_BITS];

  always_comb begin
    imr_k = imr;
    itr_k = itr;
    dmr_k = dmr;
    dtr_k = dtr;
    if (pages_differ) begin
      if (is_fetch) begin
        dmr_k = '0;
        dtr_k = '0;
      end else begin
        imr_k = '0;
        itr_k = '0;
      end
    end
  end

  assign i_hit   = imr_k[ADDR_W-1:PAGE_BITS] == vpn;
  assign d_hit   = dmr_k[ADDR_W-1:PAGE_BITS] == vpn;
  assign match_v = {i_hit, d_hit, d_hit};
  assign valid_v = {imr_k[0], dmr_k[0], dmr_k[0]} & match_v;

  always_comb begin
    rights_v[PERM_X] = super_mode ? itr_k[BIT_SX] : itr_k[BIT_UX];
    rights_v[PERM_R] = super_mode ? dtr_k[BIT_SR] : dtr_k[BIT_UR];
    rights_v[PERM_W] = super_mode ? dtr_k[BIT_SW] : dtr_k[BIT_UW];
    rights_v         = rights_v & valid_v;
  end

  assign paddr = {(itr_k[ADDR_W-1:PAGE_BITS] | dtr_k[ADDR_W-1:PAGE_BITS]),
                  vaddr[PAGE_BITS-1:0]};
  assign fault = classify(need_of(acc), rights_v, valid_v, is_fetch);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int DEPTH     = 64,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_super,
  input  logic              req_mmu_en,
  input  logic              wr_en,
  input  logic              wr_sel_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_match,
  input  logic [ADDR_W-1:0] wr_xlate,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic [2:0]        rsp_fault
);
  logic [IDX_W-1:0]       look_idx;
  logic [1:0][ADDR_W-1:0] ent_match;
  logic [1:0][ADDR_W-1:0] ent_xlate;
  logic                   pages_differ;
  logic [2:0]             match_v, valid_v, rights_v, chk_fault;
  logic [ADDR_W-1:0]      chk_paddr;

  assign look_idx = req_vaddr[PAGE_BITS +: IDX_W];

  // index 0: instruction buffer, index 1: data buffer
  for (genvar g = 0; g < 2; g++) begin : g_buf
    tlb_entry_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_sel_data == g[0])),
      .wr_idx   (wr_idx),
      .wr_match (wr_match),
      .wr_xlate (wr_xlate),
      .rd_idx   (look_idx),
      .rd_match (ent_match[g]),
      .rd_xlate (ent_xlate[g])
    );
  end

  tlb_merge_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_merge (
    .vaddr        (req_vaddr),
    .acc          (req_acc),
    .super_mode   (req_super),
    .imr          (ent_match[0]),
    .itr          (ent_xlate[0]),
    .dmr          (ent_match[1]),
    .dtr          (ent_xlate[1]),
    .pages_differ (pages_differ),
    .match_v      (match_v),
    .valid_v      (valid_v),
    .rights_v     (rights_v),
    .paddr        (chk_paddr),
    .fault        (chk_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (req_mmu_en) begin
          rsp_paddr <= chk_paddr;
          rsp_perm  <= rights_v;
          rsp_fault <= chk_fault;
        end else begin
          rsp_paddr <= req_vaddr;
          rsp_perm  <= 3'b111;
          rsp_fault <= FLT_NONE;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_sva.sv
module tlb_xlate_sva
  import tlb_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_acc,
  input logic              req_mmu_en,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_perm,
  input logic [2:0]        rsp_fault,
  input logic [2:0]        valid_v,
  input logic [2:0]        rights_v
);
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_bypass_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mmu_en) |=>
      (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && rsp_fault == FLT_NONE));
  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));
  p_success_iff_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mmu_en) |=>
      ((rsp_fault == FLT_NONE) == ((rsp_perm & need_of($past(req_acc))) != 3'b000)));
  p_fetch_fault_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mmu_en && req_acc == ACC_FETCH) |=>
      (rsp_fault == FLT_NONE || rsp_fault == FLT_IPAGE || rsp_fault == FLT_IMISS));
  p_data_fault_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mmu_en && req_acc != ACC_FETCH) |=>
      (rsp_fault == FLT_NONE || rsp_fault == FLT_DPAGE || rsp_fault == FLT_DMISS));
  p_right_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rights_v & ~valid_v) == 3'b000);
endmodule

bind tlb_xlate tlb_xlate_sva #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .req_acc    (req_acc),
  .req_mmu_en (req_mmu_en),
  .rsp_valid  (rsp_valid),
  .rsp_paddr  (rsp_paddr),
  .rsp_perm   (rsp_perm),
  .rsp_fault  (rsp_fault),
  .valid_v    (valid_v),
  .rights_v   (rights_v)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_super = 1'b0;
  logic        req_mmu_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel_data = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_match = '0;
  logic [31:0] wr_xlate = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [2:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_super(req_super), .req_mmu_en(req_mmu_en),
    .wr_en(wr_en), .wr_sel_data(wr_sel_data), .wr_idx(wr_idx),
    .wr_match(wr_match), .wr_xlate(wr_xlate), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_entry(input bit dsel, input logic [5:0] idx, input logic [31:0] m, input logic [31:0] x);
    @(negedge clk);
    wr_en = 1'b1; wr_sel_data = dsel; wr_idx = idx; wr_match = m; wr_xlate = x;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input bit sup, input bit en,
                        input logic [31:0] e_pa, input logic [2:0] e_perm, input logic [2:0] e_flt,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_super = sup; req_mmu_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_paddr == e_pa, {req, " paddr"}, rsp_paddr, e_pa);
    chk(rsp_perm == e_perm, {req, " perm"}, {29'd0, rsp_perm}, {29'd0, e_perm});
    chk(rsp_fault == e_flt, {req, " fault"}, {29'd0, rsp_fault}, {29'd0, e_flt});
  endtask

  task automatic t_reset_state;
    chk(rsp_valid == 1'b0, "R1 valid", {31'd0, rsp_valid}, 32'd0);
    chk(rsp_paddr == 32'd0, "R1 paddr", rsp_paddr, 32'd0);
    chk(rsp_perm == 3'd0 && rsp_fault == 3'd0, "R1 perm/fault", {26'd0, rsp_perm, rsp_fault}, 32'd0);
  endtask

  task automatic t_empty_misses;
    lookup(32'h0000_2ABC, 2'd0, 1'b0, 1'b1, 32'h0000_0ABC, 3'b000, 3'd3, "R1 R9 fetch miss");
    lookup(32'h0000_2ABC, 2'd1, 1'b1, 1'b1, 32'h0000_0ABC, 3'b000, 3'd4, "R1 R9 load miss");
    lookup(32'h0000_2ABC, 2'd2, 1'b0, 1'b1, 32'h0000_0ABC, 3'b000, 3'd4, "R1 R9 store miss");
  endtask

  task automatic t_bypass;
    lookup(32'hDEAD_BEEF, 2'd1, 1'b0, 1'b0, 32'hDEAD_BEEF, 3'b111, 3'd0, "R3 bypass load");
    lookup(32'h0000_2ABC, 2'd0, 1'b0, 1'b0, 32'h0000_2ABC, 3'b111, 3'd0, "R3 bypass fetch");
  endtask

  task automatic t_handshake;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle no response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_data_rights;
    // data idx 1: user read, supervisor read and write
    put_entry(1'b1, 6'd1, 32'h0000_2001, 32'h1234_6000 | 32'h340);
    lookup(32'h0000_2ABC, 2'd1, 1'b0, 1'b1, 32'h1234_6ABC, 3'b001, 3'd0, "R6 R7 user load");
    lookup(32'h0000_2ABC, 2'd2, 1'b0, 1'b1, 32'h1234_6ABC, 3'b001, 3'd2, "R6 R9 user store page fault");
    lookup(32'h0000_2ABC, 2'd2, 1'b1, 1'b1, 32'h1234_6ABC, 3'b011, 3'd0, "R6 sup store");
    lookup(32'h0000_2ABC, 2'd0, 1'b0, 1'b1, 32'h0000_0ABC, 3'b000, 3'd3, "R5 R9 fetch drops data");
    lookup(32'h0000_2ABC, 2'd3, 1'b0, 1'b1, 32'h1234_6ABC, 3'b001, 3'd0, "R8 code 3 as load");
  endtask

  task automatic t_merged;
    // instruction idx 1 on the same page: user execute only
    put_entry(1'b0, 6'd1, 32'h0000_2001, 32'h1234_6040);
    lookup(32'h0000_2ABC, 2'd0, 1'b0, 1'b1, 32'h1234_6ABC, 3'b101, 3'd0, "R6 merged user fetch");
    lookup(32'h0000_2ABC, 2'd0, 1'b1, 1'b1, 32'h1234_6ABC, 3'b011, 3'd1, "R9 sup fetch page fault");
    lookup(32'h0008_2ABC, 2'd1, 1'b0, 1'b1, 32'h1234_6ABC, 3'b000, 3'd4, "R4 vpn mismatch miss");
  endtask

  task automatic t_conflict;
    put_entry(1'b0, 6'd2, 32'h0000_4001, 32'h0ABC_E0C0);
    put_entry(1'b1, 6'd2, 32'h0000_4001, 32'h5555_43C0);
    lookup(32'h0000_4010, 2'd0, 1'b0, 1'b1, 32'h0ABC_E010, 3'b100, 3'd0, "R5 conflict fetch");
    lookup(32'h0000_4010, 2'd1, 1'b0, 1'b1, 32'h5555_4010, 3'b011, 3'd0, "R5 conflict load");
  endtask

  task automatic t_same_cycle_write;
    @(negedge clk);
    wr_en = 1'b1; wr_sel_data = 1'b1; wr_idx = 6'd3;
    wr_match = 32'h0000_6001; wr_xlate = 32'h0001_0040;
    req_valid = 1'b1; req_vaddr = 32'h0000_6000; req_acc = 2'd1; req_super = 1'b0; req_mmu_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk(rsp_fault == 3'd4, "R10 old entry seen", {29'd0, rsp_fault}, 32'd4);
    lookup(32'h0000_6000, 2'd1, 1'b0, 1'b1, 32'h0001_0000, 3'b001, 3'd0, "R10 new entry seen");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_empty_misses();
    t_bypass();
    t_handshake();
    t_data_rights();
    t_merged();
    t_conflict();
    t_same_cycle_write();
    t_handshake();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule